// File: doc/BRIEF.md
# Reconfigurable Functional-Unit Grid Accelerator

This block runs custom instructions on a rectangular grid of identical functional units that sits right next to a processor's register file. Software first loads configuration words into a small on-chip store. The custom-instruction number is the store address, so no search is made. A configuration word chooses an operation for every unit and two operand sources for every unit. It also names the source register of each input latch, the destination register of each result and the unit that produces that result. Finally it gives the operand count, the result count and the number of evaluation cycles.

A start pulse carries the instruction number. The block then moves through four steps:
- It fetches operands through a limited set of register-file read ports, one group per cycle.
- It lets the grid settle for the configured number of cycles.
- It writes results back through a limited set of write ports, one group per cycle.
- It pulses done.

Each unit registers its output. A unit may take its operands from any input latch, from any unit in a higher row, or from its direct left or right neighbour in the same row. Every other source reads as zero. The register-file ports carry no valid/ready pair and have no back-pressure. The shared file is assumed to serve every request in the cycle it is made. Read data is taken in the same cycle as the address, and a write is taken at the clock edge that ends the write cycle.

Top module: `cgra_accel`

## Requirements
- R1: While rst_n is low, busy, done, every rd_en bit and every wr_en bit are 0.
- R2: A word written with cfg_we at cfg_addr is the one used by a later start whose ci_idx equals that address. The fields are packed from bit 0 upward in this order:
  - per unit u = row*COLS+col, 14 bits each: op [3:0], srcA [8:4], srcB [13:9];
  - four 4-bit input-latch source registers;
  - two 4-bit destination registers;
  - two 4-bit result-unit numbers;
  - a 3-bit operand count;
  - a 2-bit result count;
  - a 4-bit evaluation count.
- R3: Reads take ceil(N/RD_PORTS) cycles for N operands. In read group g, port p is enabled only when latch index g*RD_PORTS+p is below N, and it then presents that latch's source register. Enabled ports always form a contiguous run from port 0.
- R4: Op codes are 0 pass A, 1 A+B, 2 A−B, 3 AND, 4 OR, 5 XOR, 6 A<<B[4:0], 7 logical A>>B[4:0] and 8 arithmetic A>>B[4:0]. Codes 9 to 15 give 0.
- R5: Source numbers 0 to 3 select input latches 0 to 3. Source 4+v selects unit v, but only if unit v is in a higher row or is the immediate left or right neighbour in the same row. All other source numbers, including the unit itself and numbers 20 to 31, read 0.
- R6: On start, every unit output and every input latch clear to 0. Latches with no operand loaded stay 0. The units then update together, once per evaluation cycle, for max(E,1) cycles, and they hold their values outside those cycles.
- R7: Writes take ceil(M/WR_PORTS) cycles for M results. In write group g, port p writes result k = g*WR_PORTS+p to its destination register, with the output of its result unit as the data. Reads and writes never share a cycle.
- R8: done is high for exactly one cycle, the cycle after the last write cycle, or the cycle after the last evaluation cycle when M is 0. busy is low in that cycle.
- R9: A start while busy is high is ignored. A start in the done cycle is accepted. busy rises only in the cycle after an accepted start.
- R10: An instruction with zero operands skips the read phase and begins evaluating in the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled when idle |
| ci_idx | input | 3 | Custom-instruction number to run |
| busy | output | 1 | High from the cycle after acceptance until done |
| done | output | 1 | One-cycle completion pulse |
| cfg_we | input | 1 | Configuration store write enable |
| cfg_addr | input | 3 | Configuration store write address |
| cfg_wdata | input | 265 | Configuration word |
| rd_en | output | 2 | Per-port register read enable |
| rd_addr | output | 2x4 | Per-port register read address |
| rd_data | input | 2x32 | Per-port register read data, same cycle |
| wr_en | output | 1 | Per-port register write enable |
| wr_addr | output | 1x4 | Per-port write address |
| wr_data | output | 1x32 | Per-port write data |

## Verification
The done pulse of one instruction and the acceptance of the next start can fall in the same cycle. The bench runs until only the done cycle is left in its model's schedule, then raises start for that edge, and expects reads or evaluation of the new instruction to follow at once. A start raised two cycles into a busy period must instead leave the schedule unchanged. Every output is compared on every cycle against a behavioural model that computes the grid's values and each port's timing from the configuration fields alone.

// File: rtl/cgra_pkg.sv
package cgra_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_SRA  = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_EVAL  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;
endpackage

// File: rtl/cgra_cfg_store.sv
module cgra_cfg_store #(
  parameter int CFGW = 64,
  parameter int NCI  = 8,
  localparam int IW  = $clog2(NCI)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IW-1:0]   waddr,
  input  logic [CFGW-1:0] wdata,
  input  logic [IW-1:0]   raddr,
  output logic [CFGW-1:0] rdata
);
  logic [CFGW-1:0] mem [NCI];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // direct indexing by instruction number, no lookup
  assign rdata = mem[raddr];
endmodule

// File: rtl/cgra_cell.sv
module cgra_cell import cgra_pkg::*; #(
  parameter int DW   = 32,
  parameter int NIN  = 4,
  parameter int NU   = 16,
  parameter int COLS = 4,
  parameter int SW   = 5,
  parameter int ROW  = 0,
  parameter int COL  = 0,
  localparam int NSEL = 1 << SW,
  localparam int SHW  = $clog2(DW)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       clr,
  input  logic [OPW-1:0]             op,
  input  logic [SW-1:0]              sel_a,
  input  logic [SW-1:0]              sel_b,
  input  logic [NSEL-1:0][DW-1:0]    src_bus,
  output logic [DW-1:0]              q
);
  // reachability of a source from this grid position
  function automatic logic reachable(input logic [SW-1:0] s);
    int si, v, vr, vc;
    si = int'(s);
    if (si < NIN) return 1'b1;
    if (si >= NIN + NU) return 1'b0;
    v  = si - NIN;
    vr = v / COLS;
    vc = v % COLS;
    return (vr < ROW) || ((vr == ROW) && ((vc == COL - 1) || (vc == COL + 1)));
  endfunction

  logic [DW-1:0]  a, b, res;
  logic [SHW-1:0] shamt;

  always_comb begin
    a     = reachable(sel_a) ? src_bus[sel_a] : '0;
    b     = reachable(sel_b) ? src_bus[sel_b] : '0;
    shamt = b[SHW-1:0];
    case (op_e'(op))
      OP_PASS: res = a;
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SLL:  res = a << shamt;
      OP_SRL:  res = a >> shamt;
      OP_SRA:  res = $signed(a) >>> shamt;
      default: res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= res;
  end
endmodule

// File: rtl/cgra_fabric.sv
module cgra_fabric import cgra_pkg::*; #(
  parameter int DW   = 32,
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int NIN  = 4,
  localparam int NU   = ROWS * COLS,
  localparam int SW   = $clog2(NIN + NU),
  localparam int NSEL = 1 << SW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     clr,
  input  logic [NIN-1:0][DW-1:0]   lat,
  input  logic [NU-1:0][OPW-1:0]   ops,
  input  logic [NU-1:0][SW-1:0]    sel_a,
  input  logic [NU-1:0][SW-1:0]    sel_b,
  output logic [NU-1:0][DW-1:0]    q
);
  logic [NSEL-1:0][DW-1:0] bus;

  always_comb begin
    bus = '0;
    for (int i = 0; i < NIN; i++) bus[i] = lat[i];
    for (int u = 0; u < NU; u++) bus[NIN + u] = q[u];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      cgra_cell #(
        .DW(DW), .NIN(NIN), .NU(NU), .COLS(COLS), .SW(SW), .ROW(r), .COL(c)
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .clr     (clr),
        .op      (ops[r*COLS + c]),
        .sel_a   (sel_a[r*COLS + c]),
        .sel_b   (sel_b[r*COLS + c]),
        .src_bus (bus),
        .q       (q[r*COLS + c])
      );
    end
  end
endmodule

// File: rtl/cgra_seq.sv
module cgra_seq import cgra_pkg::*; #(
  parameter int RP    = 2,
  parameter int WP    = 1,
  parameter int CNW_I = 3,
  parameter int CNW_O = 2,
  parameter int EVW   = 4,
  parameter int CNTW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNW_I-1:0] new_nin,
  input  logic [CNW_I-1:0] nin,
  input  logic [CNW_O-1:0] nout,
  input  logic [EVW-1:0]   eval_n,
  output logic             accept,
  output logic             in_read,
  output logic             in_eval,
  output logic             in_write,
  output logic [CNTW-1:0]  cnt,
  output logic             busy,
  output logic             done
);
  phase_e         ph;
  logic [CNTW-1:0] last_r, last_e, last_w;

  always_comb begin
    last_r   = CNTW'((int'(nin) + RP - 1) / RP - 1);
    last_w   = CNTW'((int'(nout) + WP - 1) / WP - 1);
    last_e   = (eval_n == '0) ? '0 : CNTW'(eval_n - 1'b1);
    accept   = start && (ph == PH_IDLE);
    in_read  = (ph == PH_READ);
    in_eval  = (ph == PH_EVAL);
    in_write = (ph == PH_WRITE);
    busy     = (ph != PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          cnt <= '0;
          ph  <= (new_nin == '0) ? PH_EVAL : PH_READ;
        end
        PH_READ: if (cnt == last_r) begin
          cnt <= '0;
          ph  <= PH_EVAL;
        end else cnt <= cnt + 1'b1;
        PH_EVAL: if (cnt == last_e) begin
          cnt <= '0;
          if (nout == '0) begin
            ph   <= PH_IDLE;
            done <= 1'b1;
          end else ph <= PH_WRITE;
        end else cnt <= cnt + 1'b1;
        PH_WRITE: if (cnt == last_w) begin
          cnt  <= '0;
          ph   <= PH_IDLE;
          done <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cgra_accel.sv
module cgra_accel import cgra_pkg::*; #(
  parameter int DW       = 32,
  parameter int ROWS     = 4,
  parameter int COLS     = 4,
  parameter int NIN      = 4,
  parameter int NOUT     = 2,
  parameter int RD_PORTS = 2,
  parameter int WR_PORTS = 1,
  parameter int NREG     = 16,
  parameter int NCI      = 8,
  parameter int EVW      = 4,
  localparam int AW    = $clog2(NREG),
  localparam int CIW   = $clog2(NCI),
  localparam int NU    = ROWS * COLS,
  localparam int SW    = $clog2(NIN + NU),
  localparam int UIW   = $clog2(NU),
  localparam int CNW_I = $clog2(NIN + 1),
  localparam int CNW_O = $clog2(NOUT + 1),
  localparam int UNW   = OPW + 2 * SW,
  localparam int CFGW  = NU*UNW + (NIN + NOUT)*AW + NOUT*UIW + CNW_I + CNW_O + EVW
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [CIW-1:0]                    ci_idx,
  output logic                              busy,
  output logic                              done,
  input  logic                              cfg_we,
  input  logic [CIW-1:0]                    cfg_addr,
  input  logic [CFGW-1:0]                   cfg_wdata,
  output logic [RD_PORTS-1:0]               rd_en,
  output logic [RD_PORTS-1:0][AW-1:0]       rd_addr,
  input  logic [RD_PORTS-1:0][DW-1:0]       rd_data,
  output logic [WR_PORTS-1:0]               wr_en,
  output logic [WR_PORTS-1:0][AW-1:0]       wr_addr,
  output logic [WR_PORTS-1:0][DW-1:0]       wr_data
);
  localparam int SRC_OFF  = NU * UNW;
  localparam int DST_OFF  = SRC_OFF + NIN * AW;
  localparam int RSEL_OFF = DST_OFF + NOUT * AW;
  localparam int NIN_OFF  = RSEL_OFF + NOUT * UIW;
  localparam int NOUT_OFF = NIN_OFF + CNW_I;
  localparam int EV_OFF   = NOUT_OFF + CNW_O;
  localparam int CNTW     = $clog2(NIN + NOUT + (1 << EVW)) + 1;

  logic [CFGW-1:0] fetched, cur;
  logic [NU-1:0][OPW-1:0] u_op;
  logic [NU-1:0][SW-1:0]  u_sa, u_sb;
  logic [AW-1:0]  src_reg [NIN];
  logic [AW-1:0]  dst_reg [NOUT];
  logic [UIW-1:0] rsel    [NOUT];
  logic [CNW_I-1:0] nin_raw, nin_c, new_raw, new_c;
  logic [CNW_O-1:0] nout_raw, nout_c;
  logic [EVW-1:0]   eval_n;
  logic accept, in_read, in_eval, in_write;
  logic [CNTW-1:0] cnt;
  logic [NIN-1:0][DW-1:0] lat;
  logic [NU-1:0][DW-1:0]  uq;

  cgra_cfg_store #(.CFGW(CFGW), .NCI(NCI)) u_store (
    .clk(clk), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .raddr(ci_idx), .rdata(fetched)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cur <= '0;
    else if (accept) cur <= fetched;
  end

  for (genvar u = 0; u < NU; u++) begin : g_ufld
    assign u_op[u] = cur[u*UNW +: OPW];
    assign u_sa[u] = cur[u*UNW + OPW +: SW];
    assign u_sb[u] = cur[u*UNW + OPW + SW +: SW];
  end
  for (genvar i = 0; i < NIN; i++) begin : g_src
    assign src_reg[i] = cur[SRC_OFF + i*AW +: AW];
  end
  for (genvar k = 0; k < NOUT; k++) begin : g_dst
    assign dst_reg[k] = cur[DST_OFF + k*AW +: AW];
    assign rsel[k]    = cur[RSEL_OFF + k*UIW +: UIW];
  end

  always_comb begin
    nin_raw  = cur[NIN_OFF +: CNW_I];
    new_raw  = fetched[NIN_OFF +: CNW_I];
    nout_raw = cur[NOUT_OFF +: CNW_O];
    eval_n   = cur[EV_OFF +: EVW];
    nin_c    = (nin_raw > CNW_I'(NIN))   ? CNW_I'(NIN)  : nin_raw;
    new_c    = (new_raw > CNW_I'(NIN))   ? CNW_I'(NIN)  : new_raw;
    nout_c   = (nout_raw > CNW_O'(NOUT)) ? CNW_O'(NOUT) : nout_raw;
  end

  cgra_seq #(
    .RP(RD_PORTS), .WP(WR_PORTS), .CNW_I(CNW_I), .CNW_O(CNW_O), .EVW(EVW), .CNTW(CNTW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .new_nin(new_c), .nin(nin_c),
    .nout(nout_c), .eval_n(eval_n), .accept(accept), .in_read(in_read),
    .in_eval(in_eval), .in_write(in_write), .cnt(cnt), .busy(busy), .done(done)
  );

  // operand port sequencing
  always_comb begin
    for (int p = 0; p < RD_PORTS; p++) begin
      int idx;
      idx        = int'(cnt) * RD_PORTS + p;
      rd_en[p]   = in_read && (idx < int'(nin_c));
      rd_addr[p] = (idx < NIN) ? src_reg[idx] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      lat <= '0;
    else if (accept) lat <= '0;
    else if (in_read) begin
      for (int p = 0; p < RD_PORTS; p++) begin
        int idx;
        idx = int'(cnt) * RD_PORTS + p;
        if (idx < int'(nin_c) && idx < NIN) lat[idx] <= rd_data[p];
      end
    end
  end

  cgra_fabric #(.DW(DW), .ROWS(ROWS), .COLS(COLS), .NIN(NIN)) u_fabric (
    .clk(clk), .rst_n(rst_n), .en(in_eval), .clr(accept), .lat(lat),
    .ops(u_op), .sel_a(u_sa), .sel_b(u_sb), .q(uq)
  );

  // result port sequencing
  always_comb begin
    for (int p = 0; p < WR_PORTS; p++) begin
      int k;
      k          = int'(cnt) * WR_PORTS + p;
      wr_en[p]   = in_write && (k < int'(nout_c));
      wr_addr[p] = (k < NOUT) ? dst_reg[k] : '0;
      wr_data[p] = (k < NOUT) ? uq[rsel[k]] : '0;
    end
  end
endmodule

// File: rtl/cgra_accel_chk.sv
module cgra_accel_chk #(
  parameter int RP = 2,
  parameter int WP = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [RP-1:0] rd_en,
  input logic [WP-1:0] wr_en
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R3
  rd_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en & (rd_en + 1'b1)) == '0);
  // R3
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (|rd_en) |-> busy);
  // R7
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |-> (busy && !(|rd_en)));
endmodule

bind cgra_accel cgra_accel_chk #(.RP(RD_PORTS), .WP(WR_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_en(rd_en), .wr_en(wr_en)
);

// File: tb/cgra_accel_tb.sv
module cgra_accel_tb;
  localparam int DW = 32, ROWS = 4, COLS = 4, NIN = 4, NOUT = 2;
  localparam int RP = 2, WP = 1, NREG = 16, NCI = 8, EVW = 4;
  localparam int AW = 4, CIW = 3, NU = 16, SW = 5, UIW = 4;
  localparam int UNW = 14;
  localparam int SRC_OFF = 224, DST_OFF = 240, RSEL_OFF = 248;
  localparam int NIN_OFF = 256, NOUT_OFF = 259, EV_OFF = 261, CFGW = 265;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, busy, done, cfg_we;
  logic [CIW-1:0] ci_idx, cfg_addr;
  logic [CFGW-1:0] cfg_wdata;
  logic [RP-1:0] rd_en;
  logic [RP-1:0][AW-1:0] rd_addr;
  logic [RP-1:0][DW-1:0] rd_data;
  logic [WP-1:0] wr_en;
  logic [WP-1:0][AW-1:0] wr_addr;
  logic [WP-1:0][DW-1:0] wr_data;

  logic [DW-1:0] rf [NREG];

  always_comb begin
    for (int p = 0; p < RP; p++) rd_data[p] = rf[rd_addr[p]];
  end

  cgra_accel #(
    .DW(DW), .ROWS(ROWS), .COLS(COLS), .NIN(NIN), .NOUT(NOUT), .RD_PORTS(RP),
    .WR_PORTS(WP), .NREG(NREG), .NCI(NCI), .EVW(EVW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ci_idx(ci_idx), .busy(busy), .done(done),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  typedef struct {
    logic busy, done;
    logic [RP-1:0] rde;
    logic [AW-1:0] rda [RP];
    logic wre;
    logic [AW-1:0] wra;
    logic [DW-1:0] wrd;
  } rec_t;

  rec_t q[$];
  logic [CFGW-1:0] shadow [NCI];
  logic [CFGW-1:0] cw;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  bit pend_we = 0;
  int pend_addr = 0;
  logic [CFGW-1:0] pend_data;

  task automatic cmp(input string tag, input string nm, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] alu(input int op, input logic [DW-1:0] a,
                                        input logic [DW-1:0] b);
    case (op)
      0: return a;
      1: return a + b;
      2: return a - b;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return a << b[4:0];
      7: return a >> b[4:0];
      8: return $signed(a) >>> b[4:0];
      default: return '0;
    endcase
  endfunction

  // Builds the expected cycle-by-cycle schedule for one accepted instruction
  task automatic plan(input logic [CFGW-1:0] w);
    logic [DW-1:0] lat [NIN];
    logic [DW-1:0] uv [NU];
    logic [DW-1:0] nv [NU];
    int nin, nout, ev;
    rec_t r;
    nin  = int'(w[NIN_OFF +: 3]);
    nout = int'(w[NOUT_OFF +: 2]);
    ev   = int'(w[EV_OFF +: 4]);
    if (ev == 0) ev = 1;
    for (int i = 0; i < NIN; i++) lat[i] = (i < nin) ? rf[w[SRC_OFF + i*AW +: AW]] : '0;
    for (int u = 0; u < NU; u++) uv[u] = '0;
    for (int e = 0; e < ev; e++) begin
      for (int u = 0; u < NU; u++) begin
        logic [DW-1:0] ab [2];
        for (int j = 0; j < 2; j++) begin
          int s, v;
          s = int'(w[u*UNW + 4 + j*SW +: SW]);
          ab[j] = '0;
          if (s < NIN) ab[j] = lat[s];
          else if (s < NIN + NU) begin
            v = s - NIN;
            if ((v / COLS < u / COLS) ||
                ((v / COLS == u / COLS) && ((v % COLS == u % COLS - 1) || (v % COLS == u % COLS + 1))))
              ab[j] = uv[v];
          end
        end
        nv[u] = alu(int'(w[u*UNW +: 4]), ab[0], ab[1]);
      end
      for (int u = 0; u < NU; u++) uv[u] = nv[u];
    end
    r.busy = 1'b1; r.done = 1'b0; r.wre = 1'b0; r.wra = '0; r.wrd = '0;
    for (int g = 0; g < (nin + RP - 1) / RP; g++) begin
      for (int p = 0; p < RP; p++) begin
        r.rde[p] = (g*RP + p < nin);
        r.rda[p] = r.rde[p] ? w[SRC_OFF + (g*RP + p)*AW +: AW] : '0;
      end
      q.push_back(r);
    end
    r.rde = '0;
    for (int e = 0; e < ev; e++) q.push_back(r);
    for (int k = 0; k < nout; k++) begin
      r.wre = 1'b1;
      r.wra = w[DST_OFF + k*AW +: AW];
      r.wrd = uv[int'(w[RSEL_OFF + k*UIW +: UIW])];
      q.push_back(r);
    end
    r.busy = 1'b0; r.done = 1'b1; r.wre = 1'b0;
    q.push_back(r);
  endtask

  task automatic cyc(input bit s, input int idx);
    rec_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.busy = 0; e.done = 0; e.rde = '0; e.wre = 0; e.wra = '0; e.wrd = '0;
      for (int p = 0; p < RP; p++) e.rda[p] = '0;
    end
    cmp("R9", "busy", DW'(busy), DW'(e.busy));
    cmp("R8", "done", DW'(done), DW'(e.done));
    cmp("R3", "rd_en", DW'(rd_en), DW'(e.rde));
    for (int p = 0; p < RP; p++)
      if (e.rde[p]) cmp("R3", "rd_addr", DW'(rd_addr[p]), DW'(e.rda[p]));
    cmp("R7", "wr_en", DW'(wr_en), DW'(e.wre));
    if (e.wre) begin
      cmp("R7", "wr_addr", DW'(wr_addr[0]), DW'(e.wra));
      cmp("R4/R5/R6", "wr_data", wr_data[0], e.wrd);
      rf[e.wra] = e.wrd;
    end
    cfg_we = pend_we; cfg_addr = CIW'(pend_addr); cfg_wdata = pend_data;
    if (pend_we) shadow[pend_addr] = pend_data;
    pend_we = 0;
    start = s; ci_idx = CIW'(idx);
    if (s && !e.busy) plan(shadow[idx]);
  endtask

  task automatic load_cfg(input int idx, input logic [CFGW-1:0] w);
    pend_we = 1; pend_addr = idx; pend_data = w;
    cyc(0, 0);
  endtask

  task automatic drain();
    while (q.size() > 0) cyc(0, 0);
  endtask

  task automatic setu(input int u, input int op, input int sa, input int sb);
    cw[u*UNW +: 4] = 4'(op);
    cw[u*UNW + 4 +: SW] = SW'(sa);
    cw[u*UNW + 4 + SW +: SW] = SW'(sb);
  endtask

  task automatic sethdr(input int nin, input int nout, input int ev,
                        input int s0, input int s1, input int s2, input int s3,
                        input int d0, input int d1, input int r0, input int r1);
    cw[SRC_OFF +: 16] = {4'(s3), 4'(s2), 4'(s1), 4'(s0)};
    cw[DST_OFF +: 8]  = {4'(d1), 4'(d0)};
    cw[RSEL_OFF +: 8] = {4'(r1), 4'(r0)};
    cw[NIN_OFF +: 3]  = 3'(nin);
    cw[NOUT_OFF +: 2] = 2'(nout);
    cw[EV_OFF +: 4]   = 4'(ev);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected idle");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; ci_idx = '0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    pend_data = '0;
    for (int i = 0; i < NREG; i++) rf[i] = 32'h1111_0000 + i * 32'h0101_0013;
    rf[5] = 32'h8000_00F0; rf[6] = 32'd4; rf[14] = 32'hDEAD_BEEF;
    for (int i = 0; i < NCI; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    cmp("R1", "busy", DW'(busy), 0);
    cmp("R1", "done", DW'(done), 0);
    cmp("R1", "rd_en", DW'(rd_en), 0);
    cmp("R1", "wr_en", DW'(wr_en), 0);
    rst_n = 1;

    // add then neighbour xor, three operands over two read groups
    cw = '0; sethdr(3, 2, 2, 1, 2, 3, 0, 10, 11, 0, 1);
    setu(0, 1, 0, 1); setu(1, 5, NIN + 0, 2);
    load_cfg(0, cw);
    // all shift kinds and subtract
    cw = '0; sethdr(2, 2, 1, 5, 6, 0, 0, 12, 13, 2, 3);
    setu(0, 6, 0, 1); setu(1, 7, 0, 1); setu(2, 8, 0, 1); setu(3, 2, 0, 1);
    load_cfg(1, cw);
    // R5 illegal sources: below, self, distant same-row, out of range
    cw = '0; sethdr(1, 2, 3, 7, 0, 0, 0, 8, 9, 5, 6);
    setu(0, 0, NIN + 4, 0); setu(4, 4, NIN + 0, 0); setu(5, 1, NIN + 4, NIN + 5);
    setu(6, 4, NIN + 4, 31);
    load_cfg(2, cw);
    // four operands, no results
    cw = '0; sethdr(4, 0, 5, 1, 2, 3, 4, 0, 0, 0, 0);
    load_cfg(3, cw);
    // R10 zero operands, eval count 0, undefined op code; R2 high index
    cw = '0; sethdr(0, 1, 0, 0, 0, 0, 0, 14, 0, 0, 0);
    setu(0, 15, 0, 0);
    load_cfg(7, cw);

    cyc(1, 0);          // R2 run index 0
    cyc(0, 0);
    cyc(1, 1);          // R9 ignored while busy
    while (q.size() > 1) cyc(0, 0);
    cyc(1, 1);          // R9 accepted in done cycle
    while (q.size() > 1) cyc(0, 0);
    cyc(1, 2);
    drain();
    cyc(1, 3);
    while (q.size() > 1) cyc(0, 0);
    cyc(1, 7);          // R10 directly into evaluation
    drain();
    cyc(0, 0);

    for (int t = 0; t < 40; t++) begin
      int ix;
      ix = t % NCI;
      for (int c = 0; c < CFGW; c += 32) cw[c +: 32] = $urandom;
      cw[NIN_OFF +: 3]  = 3'($urandom % 5);
      cw[NOUT_OFF +: 2] = 2'($urandom % 3);
      for (int u = 0; u < NU; u++)
        if ($urandom % 3 == 0) cw[u*UNW + 4 +: SW] = SW'(NIN + ($urandom % NU));
      load_cfg(ix, cw);
      for (int i = 0; i < NREG; i++) if ($urandom % 4 == 0) rf[i] = $urandom;
      cyc(1, ix);
      while (q.size() > 1) cyc(0, 0);
      if (t % 2 == 0) cyc(1, ix);
      drain();
      cyc(0, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule